// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM with a 9-bit multiplexed row address alive. A free-running interval timer adds one refresh to an "owed" count at a fixed period. The period is chosen so that every one of the 512 rows is visited within the 8 ms retention window. While anything is owed and no refresh is running, the block asks an external arbiter for the memory bus. It starts a refresh cycle only on the clock edge where the request and the grant are both seen high. As a result, a refresh never interrupts an access the arbiter has already started.

A parameter selects one of two refresh styles. In CAS-before-RAS style, both column strobes fall a set number of cycles before the row strobe, and the device supplies the row itself. In RAS-only style, both column strobes stay high. The block then drives its own row counter onto the address bus and pulses the row strobe low. The counter advances once per completed refresh. Every cycle lasts the configured minimum cycle time. This time is split into a lead phase, a row-strobe-low phase and a precharge phase. The busy flag covers the whole cycle, so the arbiter can hold other traffic off until precharge is over.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and directly after it, ras_n, cas_l_n and cas_h_n are 1, and ref_req, refresh_busy and addr_oe are 0.
- R2: The owed count rises by one on every INTERVAL_CLKS-th rising clock edge after reset release. With nothing owed before, ref_req is 0 after edge INTERVAL_CLKS-1 and 1 after edge INTERVAL_CLKS.
- R3: The owed count saturates at OWED_MAX (8) and does not wrap. After ten or more intervals with no grant, a continuous grant yields exactly eight refresh cycles before ref_req falls.
- R4: ref_req is 0 while refresh_busy is 1. A grant seen while ref_req is 0 starts no cycle, so ras_n stays 1.
- R5: With ref_gnt held at 0, no strobe leaves 1, however long requests are pending.
- R6: In CAS-before-RAS style, counting from the accepting edge: both CAS lines are low for the first CSR_CLKS cycles while ras_n is 1. ras_n is then low for RC_CLKS-RP_CLKS-CSR_CLKS cycles with both CAS lines still low. All strobes are then 1, and addr_oe stays 0 throughout.
- R7: In RAS-only style, cas_l_n and cas_h_n stay 1 at all times. addr_oe is 1 for one setup cycle and for the whole row-strobe-low phase, and addr then carries the row being refreshed.
- R8: In RAS-only style, ras_n is low for RC_CLKS-RP_CLKS-1 cycles, starting one cycle after the accepting edge.
- R9: refresh_busy rises on the accepting edge and stays 1 until exactly RP_CLKS cycles after ras_n returns to 1. The whole cycle therefore lasts RC_CLKS cycles.
- R10: In RAS-only style, the rows driven are 0, 1, 2, … in order, one per completed refresh, and the row after 511 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the arbiter |
| ref_req | output | 1 | Refresh wanted and block idle |
| refresh_busy | output | 1 | Refresh cycle in progress, including precharge |
| ras_n | output | 1 | Row strobe, active low |
| cas_l_n | output | 1 | Lower-byte column strobe, active low |
| cas_h_n | output | 1 | Upper-byte column strobe, active low |
| addr | output | ROW_BITS | Row address in RAS-only style, 0 when not driven |
| addr_oe | output | 1 | Address bus drive enable |

## Verification
The assertions assume the arbiter only matters through the request/grant pair. A grant may stay high for any length of time or arrive while nothing is requested, and nothing else drives the strobes. The stimulus changes grant and reset only on falling clock edges. It holds grant either low for long stretches or high continuously, which covers the idle, backlog and back-to-back cases without ever violating the handshake. Reset is applied once at the start, so the interval phase is known from the cycle count.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_BITS      = 9,
  parameter int CLK_KHZ       = 250000,
  parameter int RETENTION_MS  = 8,
  parameter int INTERVAL_CLKS = CLK_KHZ * RETENTION_MS / (2 ** ROW_BITS),
  parameter int RC_CLKS       = 28,
  parameter int RP_CLKS       = 10,
  parameter int CSR_CLKS      = 3,
  parameter int OWED_MAX      = 8,
  parameter bit CBR_MODE      = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                refresh_busy,
  output logic                ras_n,
  output logic                cas_l_n,
  output logic                cas_h_n,
  output logic [ROW_BITS-1:0] addr,
  output logic                addr_oe
);
  localparam int LEAD_CLKS = CBR_MODE ? CSR_CLKS : 1;
  localparam int RAS_RAW   = RC_CLKS - RP_CLKS - LEAD_CLKS;
  localparam int RAS_CLKS  = (RAS_RAW < 1) ? 1 : RAS_RAW;
  localparam int TW        = $clog2(INTERVAL_CLKS + 1);
  localparam int OW        = $clog2(OWED_MAX + 1);
  localparam int PW        = $clog2(RC_CLKS + RAS_CLKS + CSR_CLKS + 1);

  typedef enum logic [1:0] {IDLE, LEAD, ACTIVE, PRE} phase_t;

  phase_t              phase_q;
  logic [PW-1:0]       cnt_q;
  logic [TW-1:0]       tmr_q;
  logic [OW-1:0]       owed_q;
  logic [ROW_BITS-1:0] row_q;

  wire tick  = (tmr_q == '0);
  wire serve = ref_req && ref_gnt;
  wire last  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    tmr_q <= TW'(INTERVAL_CLKS - 1);
    else if (tick) tmr_q <= TW'(INTERVAL_CLKS - 1);
    else           tmr_q <= tmr_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      owed_q <= '0;
    else if (tick && !serve && owed_q != OW'(OWED_MAX))
      owed_q <= owed_q + 1'b1;
    else if (serve && !tick)
      owed_q <= owed_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
    end else begin
      case (phase_q)
        IDLE:   if (serve) begin
                  phase_q <= LEAD;
                  cnt_q   <= PW'(LEAD_CLKS - 1);
                end
        LEAD:   if (last) begin
                  phase_q <= ACTIVE;
                  cnt_q   <= PW'(RAS_CLKS - 1);
                end else cnt_q <= cnt_q - 1'b1;
        ACTIVE: if (last) begin
                  phase_q <= PRE;
                  cnt_q   <= PW'(RP_CLKS - 1);
                  if (!CBR_MODE) row_q <= row_q + 1'b1;
                end else cnt_q <= cnt_q - 1'b1;
        default: if (last) phase_q <= IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign ref_req      = (owed_q != '0) && (phase_q == IDLE);
  assign refresh_busy = (phase_q != IDLE);
  assign ras_n        = (phase_q != ACTIVE);
  assign cas_l_n      = !(CBR_MODE && (phase_q == LEAD || phase_q == ACTIVE));
  assign cas_h_n      = cas_l_n;
  assign addr_oe      = !CBR_MODE && (phase_q == LEAD || phase_q == ACTIVE);
  assign addr         = addr_oe ? row_q : '0;
endmodule

module dram_refresh_sched_chk #(
  parameter int ROW_BITS = 9,
  parameter int OWED_MAX = 8,
  parameter bit CBR_MODE = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_gnt,
  input logic                ref_req,
  input logic                refresh_busy,
  input logic                ras_n,
  input logic                cas_l_n,
  input logic                cas_h_n,
  input logic                addr_oe,
  input logic [ROW_BITS-1:0] row_q,
  input logic [$clog2(OWED_MAX+1)-1:0] owed_q
);
  assert_owed_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= ($clog2(OWED_MAX+1))'(OWED_MAX));
  assert_req_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !refresh_busy);
  assert_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_busy && !ref_gnt |=> !refresh_busy);
  assert_cas_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    CBR_MODE && $fell(ras_n) |-> !cas_l_n && !cas_h_n && $past(!cas_l_n));
  assert_cas_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !CBR_MODE |-> cas_l_n && cas_h_n);
  assert_addr_when_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !CBR_MODE && !ras_n |-> addr_oe);
  assert_busy_on_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && ref_gnt |=> refresh_busy);
  assert_ras_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> refresh_busy);
  assert_row_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !CBR_MODE && $rose(ras_n) |-> row_q == ROW_BITS'($past(row_q) + 1'b1));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .ROW_BITS(ROW_BITS), .OWED_MAX(OWED_MAX), .CBR_MODE(CBR_MODE)
) u_chk (.*);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int IV_C = 200;
  localparam int IV_R = 20;
  localparam int RC = 10, RP = 3, CSR = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gnt_c = 1'b0, gnt_r = 1'b0;
  logic req_c, busy_c, ras_c, casl_c, cash_c, oe_c;
  logic req_r, busy_r, ras_r, casl_r, cash_r, oe_r;
  logic [8:0] addr_c, addr_r;
  int errors = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dram_refresh_sched #(.INTERVAL_CLKS(IV_C), .RC_CLKS(RC), .RP_CLKS(RP),
    .CSR_CLKS(CSR), .CBR_MODE(1'b1)) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_c), .ref_req(req_c),
    .refresh_busy(busy_c), .ras_n(ras_c), .cas_l_n(casl_c), .cas_h_n(cash_c),
    .addr(addr_c), .addr_oe(oe_c));

  dram_refresh_sched #(.INTERVAL_CLKS(IV_R), .RC_CLKS(RC), .RP_CLKS(RP),
    .CSR_CLKS(CSR), .CBR_MODE(1'b0)) u_dram_refresh_sched_ro (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_r), .ref_req(req_r),
    .refresh_busy(busy_r), .ras_n(ras_r), .cas_l_n(casl_r), .cas_h_n(cash_r),
    .addr(addr_r), .addr_oe(oe_r));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ras_c && casl_c && cash_c && ras_r && casl_r && cash_r, "R1 strobes", 0, 1);
    chk(!req_c && !busy_c && !oe_c && !req_r && !busy_r && !oe_r, "R1 flags", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_c && !req_c && !busy_c, "R1 after release", busy_c, 0);
  endtask

  task automatic t_interval;
    wait_to(IV_C - 1);
    chk(!req_c, "R2 before interval", req_c, 0);
    wait_to(IV_C);
    chk(req_c, "R2 at interval", req_c, 1);
  endtask

  task automatic t_no_grant;
    int bad = 0;
    while (cyc < 10 * IV_C) begin
      if (!ras_c || !casl_c || !cash_c || busy_c) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 idle while not granted", bad, 0);
    chk(req_c, "R5 request pending", req_c, 1);
  endtask

  task automatic t_cbr_backlog;
    int falls = 0;
    logic prev;
    gnt_c = 1'b1;
    @(negedge clk);
    for (int k = 0; k <= RC; k++) begin
      chk(casl_c == !(k < RC - RP) && cash_c == casl_c, "R6 cas", casl_c, !(k < RC - RP));
      chk(ras_c == !(k >= CSR && k < RC - RP), "R6 ras", ras_c, !(k >= CSR && k < RC - RP));
      chk(!oe_c, "R6 no addr drive", oe_c, 0);
      chk(busy_c == (k < RC), "R9 busy", busy_c, k < RC);
      if (k > 0 && k < RC) chk(!req_c, "R4 no req while busy", req_c, 0);
      if (k == CSR) falls++;
      @(negedge clk);
    end
    prev = ras_c;
    while (cyc < 10 * IV_C + 150) begin
      if (prev && !ras_c) falls++;
      prev = ras_c;
      @(negedge clk);
    end
    chk(falls == 8, "R3 saturated backlog", falls, 8);
    chk(!req_c && !busy_c, "R4 grant without request", req_c, 0);
    chk(ras_c, "R4 no cycle on bare grant", ras_c, 1);
    gnt_c = 1'b0;
  endtask

  task automatic t_ras_only;
    int exp_row = 0, seen = 0, bad = 0, low = 0;
    logic prev;
    gnt_r = 1'b1;
    @(negedge clk);
    for (int k = 0; k < RC; k++) begin
      chk(casl_r && cash_r, "R7 cas high", casl_r, 1);
      chk(oe_r == (k < RC - RP), "R7 addr drive", oe_r, k < RC - RP);
      if (k < RC - RP) chk(addr_r == 9'd0, "R7 row on bus", addr_r, 0);
      chk(ras_r == !(k >= 1 && k < RC - RP), "R8 ras window", ras_r, !(k >= 1 && k < RC - RP));
      chk(busy_r, "R9 busy ras-only", busy_r, 1);
      if (!ras_r) low++;
      @(negedge clk);
    end
    chk(low == RC - RP - 1, "R8 ras low length", low, RC - RP - 1);
    chk(!busy_r, "R9 busy ends after precharge", busy_r, 0);
    exp_row = 1;
    prev = ras_r;
    while (seen < 512 && cyc < 140000) begin
      if (prev && !ras_r) begin
        if (addr_r != 9'(exp_row)) begin
          bad++;
          chk(1'b0, "R10 row order", addr_r, exp_row);
        end
        if (!casl_r || !cash_r) bad++;
        exp_row = (exp_row + 1) % 512;
        seen++;
      end
      prev = ras_r;
      @(negedge clk);
    end
    chk(seen == 512, "R10 refresh count", seen, 512);
    chk(bad == 0, "R10 sequence", bad, 0);
    chk(exp_row == 1, "R10 wrapped to 0", exp_row, 1);
    gnt_r = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_interval();
    t_no_grant();
    t_cbr_backlog();
    t_ras_only();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule